// File: doc/BRIEF.md
# Segmented Bank Address Generator

This block turns a 16-bit offset from a processor core into a 24-bit physical address. The address space is cut into 256 banks of 64 KB, and the upper eight address bits come from one of five bank registers: program, data, user stack, system stack and additional. The decoder names an access class (code, data, stack or additional) for every access. The block picks the matching bank register and joins its value to the offset. For stack accesses the stack-select status flag picks the system or user stack bank.

A bank prefix from instruction decode is held as pending. Until the following instruction signals completion, the data-class and additional-class accesses of that instruction use the bank named by the prefix. Code fetches and stack accesses keep their usual banks. Software writes and reads the bank registers through a small port. After reset the program bank holds the bank value from the reset vector, and every other bank register holds zero.

Top module: `bank_addr_gen`

## Requirements
- R1: `phys_addr` equals {selected bank, `acc_offset`} combinationally; an offset of 0xFFFF never alters the bank field.
- R2: Class code (`acc_space`=0) always uses the program bank (id 0), even while a prefix is pending.
- R3: Class stack (`acc_space`=2) uses the system stack bank (id 3) when `stk_sel`=1 and the user stack bank (id 2) when `stk_sel`=0; a pending prefix does not change this.
- R4: With no prefix pending, class data (`acc_space`=1) uses the data bank (id 1) and class additional (`acc_space`=3) uses the additional bank (id 4).
- R5: While `rst_n` is low at a clock edge, bank id 0 loads `rst_prog_bank` and ids 1 to 4 clear to 0x00.
- R6: A write (`wr_en`, `wr_sel`, `wr_data`) changes the bank used only from the next cycle on; an access in the write cycle sees the old value.
- R7: `rd_data` shows the current value of the register named by `rd_sel`; ids 5 to 7 read as 0x00.
- R8: Writes with `wr_sel` of 5 to 7 are ignored and change no register.
- R9: A `pfx_valid` pulse with a valid id makes data and additional class accesses use that bank from the next cycle until a cycle with `insn_done` high (and no new prefix) clears it.
- R10: With several prefixes before completion, the last one received wins; a prefix arriving in the same cycle as `insn_done` stays pending.
- R11: A prefix with an id of 5 to 7 is ignored: the pending state is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_prog_bank | input | 8 | Program bank value from the reset vector |
| acc_space | input | 2 | Access class: 0 code, 1 data, 2 stack, 3 additional |
| acc_offset | input | 16 | Offset within the bank |
| stk_sel | input | 1 | Stack-select status flag (1 system, 0 user) |
| wr_en | input | 1 | Bank register write strobe |
| wr_sel | input | 3 | Register id to write (0 prog, 1 data, 2 user stack, 3 system stack, 4 additional) |
| wr_data | input | 8 | Write value |
| rd_sel | input | 3 | Register id to read |
| rd_data | output | 8 | Read value |
| pfx_valid | input | 1 | Bank prefix decoded this cycle |
| pfx_sel | input | 3 | Bank id named by the prefix |
| insn_done | input | 1 | Current instruction completes this cycle |
| phys_addr | output | 24 | Physical address |

## Verification
The hardest situation to reach is one where a pending prefix meets every other event in the same cycle. A second prefix, an invalid prefix or a completion may arrive while one is already pending. Accesses of every class then have to be compared against the redirected bank. The stimulus writes a distinct value into each bank register first, so any wrong choice of register shows up in the address. It then runs prefix chains with class changes on each cycle. Completion is pulsed alone, together with a new prefix, and together with an invalid prefix.

// File: rtl/bank_pkg.sv
package bank_pkg;
   localparam int unsigned NUM_BANKS = 5;
   localparam int unsigned ID_W      = 3;
   localparam int unsigned SPACE_W   = 2;

   typedef enum logic [SPACE_W-1:0] {
      SPC_CODE  = 2'd0,
      SPC_DATA  = 2'd1,
      SPC_STACK = 2'd2,
      SPC_EXTRA = 2'd3
   } space_e;

   typedef enum logic [ID_W-1:0] {
      BK_PROG  = 3'd0,
      BK_DATA  = 3'd1,
      BK_USTK  = 3'd2,
      BK_SSTK  = 3'd3,
      BK_EXTRA = 3'd4
   } bank_id_e;

   function automatic logic id_ok(input logic [ID_W-1:0] id);
      return id < ID_W'(NUM_BANKS);
   endfunction
endpackage

// File: rtl/bank_regfile.sv
module bank_regfile
   import bank_pkg::*;
#(
   parameter int unsigned BANK_W = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [BANK_W-1:0]                rst_prog_bank,
   input  logic                             wr_en,
   input  logic [ID_W-1:0]                  wr_sel,
   input  logic [BANK_W-1:0]                wr_data,
   input  logic [ID_W-1:0]                  rd_sel,
   output logic [BANK_W-1:0]                rd_data,
   output logic [NUM_BANKS-1:0][BANK_W-1:0] banks
);
   if (BANK_W < 1) begin : g_bad_width
      $error("bank_regfile: BANK_W must be at least 1");
   end

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_reg
      localparam logic [ID_W-1:0] MY_ID = ID_W'(i);
      if (i == int'(BK_PROG)) begin : g_prog
         always_ff @(posedge clk) begin
            if (!rst_n)                        banks[i] <= rst_prog_bank;
            else if (wr_en && wr_sel == MY_ID) banks[i] <= wr_data;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)                        banks[i] <= '0;
            else if (wr_en && wr_sel == MY_ID) banks[i] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int j = 0; j < NUM_BANKS; j++) begin
         if (rd_sel == ID_W'(j)) rd_data = banks[j];
      end
   end
endmodule

// File: rtl/bank_prefix.sv
module bank_prefix
   import bank_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pfx_valid,
   input  logic [ID_W-1:0] pfx_sel,
   input  logic            insn_done,
   output logic            pend_valid,
   output logic [ID_W-1:0] pend_sel
);
   logic take;
   assign take = pfx_valid && id_ok(pfx_sel);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_sel   <= BK_DATA;
      end else if (take) begin
         pend_valid <= 1'b1;
         pend_sel   <= pfx_sel;
      end else if (insn_done) begin
         pend_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/bank_select.sv
module bank_select
   import bank_pkg::*;
#(
   parameter int unsigned BANK_W = 8,
   parameter int unsigned OFS_W  = 16,
   localparam int unsigned ADDR_W = BANK_W + OFS_W
) (
   input  logic [NUM_BANKS-1:0][BANK_W-1:0] banks,
   input  logic [SPACE_W-1:0]               acc_space,
   input  logic                             stk_sel,
   input  logic                             pend_valid,
   input  logic [ID_W-1:0]                  pend_sel,
   input  logic [OFS_W-1:0]                 acc_offset,
   output logic [ADDR_W-1:0]                phys_addr
);
   if (OFS_W < 1) begin : g_bad_ofs
      $error("bank_select: OFS_W must be at least 1");
   end

   logic [ID_W-1:0]   id;
   logic [BANK_W-1:0] bank;

   always_comb begin
      unique case (space_e'(acc_space))
         SPC_CODE:  id = BK_PROG;
         SPC_STACK: id = stk_sel ? BK_SSTK : BK_USTK;
         SPC_DATA:  id = pend_valid ? pend_sel : BK_DATA;
         SPC_EXTRA: id = pend_valid ? pend_sel : BK_EXTRA;
         default:   id = BK_PROG;
      endcase
   end

   always_comb begin
      bank = '0;
      for (int j = 0; j < NUM_BANKS; j++) begin
         if (id == ID_W'(j)) bank = banks[j];
      end
   end

   assign phys_addr = {bank, acc_offset};
endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
   import bank_pkg::*;
#(
   parameter int unsigned BANK_W = 8,
   parameter int unsigned OFS_W  = 16,
   localparam int unsigned ADDR_W = BANK_W + OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] rst_prog_bank,
   input  logic [1:0]        acc_space,
   input  logic [OFS_W-1:0]  acc_offset,
   input  logic              stk_sel,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [BANK_W-1:0] wr_data,
   input  logic [2:0]        rd_sel,
   output logic [BANK_W-1:0] rd_data,
   input  logic              pfx_valid,
   input  logic [2:0]        pfx_sel,
   input  logic              insn_done,
   output logic [ADDR_W-1:0] phys_addr
);
   logic [NUM_BANKS-1:0][BANK_W-1:0] banks;
   logic                             pend_valid;
   logic [ID_W-1:0]                  pend_sel;

   bank_regfile #(.BANK_W(BANK_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .rst_prog_bank(rst_prog_bank),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .banks(banks)
   );

   bank_prefix u_pfx (
      .clk(clk), .rst_n(rst_n), .pfx_valid(pfx_valid), .pfx_sel(pfx_sel),
      .insn_done(insn_done), .pend_valid(pend_valid), .pend_sel(pend_sel)
   );

   bank_select #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_sel (
      .banks(banks), .acc_space(acc_space), .stk_sel(stk_sel),
      .pend_valid(pend_valid), .pend_sel(pend_sel),
      .acc_offset(acc_offset), .phys_addr(phys_addr)
   );
endmodule

// File: rtl/bank_addr_gen_chk.sv
module bank_addr_gen_chk #(
   parameter int unsigned BANK_W = 8,
   parameter int unsigned OFS_W  = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [1:0]               acc_space,
   input logic [OFS_W-1:0]         acc_offset,
   input logic                     stk_sel,
   input logic                     wr_en,
   input logic [2:0]               wr_sel,
   input logic [BANK_W-1:0]        wr_data,
   input logic [2:0]               rd_sel,
   input logic [BANK_W-1:0]        rd_data,
   input logic                     pfx_valid,
   input logic [2:0]               pfx_sel,
   input logic                     insn_done,
   input logic [BANK_W+OFS_W-1:0]  phys_addr
);
   logic [BANK_W-1:0] pbank;
   assign pbank = phys_addr[BANK_W+OFS_W-1:OFS_W];

   assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      phys_addr[OFS_W-1:0] == acc_offset);

   assert_code_prog_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_space == 2'd0 && rd_sel == 3'd0) |-> pbank == rd_data);

   assert_stack_sys_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_space == 2'd2 && stk_sel && rd_sel == 3'd3) |-> pbank == rd_data);

   assert_stack_usr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_space == 2'd2 && !stk_sel && rd_sel == 3'd2) |-> pbank == rd_data);

   assert_write_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 3'd1 && rd_sel == 3'd1) |=>
         (rd_sel != 3'd1 || rd_data == $past(wr_data)));

   assert_bad_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel > 3'd4) |-> rd_data == '0);

   assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_done && !pfx_valid) |=>
         ((acc_space != 2'd1 || rd_sel != 3'd1) || pbank == rd_data));

   assert_prefix_redirect_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pfx_valid && pfx_sel < 3'd5) |=>
         ((acc_space != 2'd1 || rd_sel != $past(pfx_sel)) || pbank == rd_data));
endmodule

bind bank_addr_gen bank_addr_gen_chk #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_space(acc_space), .acc_offset(acc_offset),
   .stk_sel(stk_sel), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
   .rd_sel(rd_sel), .rd_data(rd_data), .pfx_valid(pfx_valid),
   .pfx_sel(pfx_sel), .insn_done(insn_done), .phys_addr(phys_addr)
);

// File: tb/tb_bank_addr_gen.sv
module tb_bank_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  rst_prog_bank;
   logic [1:0]  acc_space;
   logic [15:0] acc_offset;
   logic        stk_sel;
   logic        wr_en;
   logic [2:0]  wr_sel;
   logic [7:0]  wr_data;
   logic [2:0]  rd_sel;
   logic [7:0]  rd_data;
   logic        pfx_valid;
   logic [2:0]  pfx_sel;
   logic        insn_done;
   logic [23:0] phys_addr;

   always #4 clk = ~clk;

   bank_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .rst_prog_bank(rst_prog_bank),
      .acc_space(acc_space), .acc_offset(acc_offset), .stk_sel(stk_sel),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .pfx_valid(pfx_valid),
      .pfx_sel(pfx_sel), .insn_done(insn_done), .phys_addr(phys_addr)
   );

   typedef struct {
      logic [23:0] addr;
      logic [7:0]  rd;
      string       tag;
   } exp_t;

   exp_t q[$];
   event chk_ev;
   int   checks = 0;
   int   errors = 0;

   logic [7:0] m_bank [5];
   logic       m_pend;
   logic [2:0] m_psel;

   logic       nx_we;
   logic [2:0] nx_ws;
   logic [7:0] nx_wd;
   logic       nx_pv;
   logic [2:0] nx_ps;
   logic       nx_done;

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         exp_t e;
         @(chk_ev);
         #1;
         e = q.pop_front();
         checks++;
         if (phys_addr !== e.addr) begin
            errors++;
            $display("FAIL %s addr: actual %h expected %h", e.tag, phys_addr, e.addr);
         end
         checks++;
         if (rd_data !== e.rd) begin
            errors++;
            $display("FAIL %s rd_data: actual %h expected %h", e.tag, rd_data, e.rd);
         end
      end
   end

   task automatic step(input logic [1:0] sp, input logic [15:0] ofs,
                       input logic s, input logic [2:0] rs, input string tag);
      exp_t e;
      logic [2:0] id;
      @(negedge clk);
      acc_space = sp; acc_offset = ofs; stk_sel = s; rd_sel = rs;
      wr_en = nx_we; wr_sel = nx_ws; wr_data = nx_wd;
      pfx_valid = nx_pv; pfx_sel = nx_ps; insn_done = nx_done;
      case (sp)
         2'd0: id = 3'd0;
         2'd2: id = s ? 3'd3 : 3'd2;
         2'd1: id = m_pend ? m_psel : 3'd1;
         default: id = m_pend ? m_psel : 3'd4;
      endcase
      e.addr = {m_bank[id], ofs};
      e.rd   = (rs < 3'd5) ? m_bank[rs] : 8'h00;
      e.tag  = tag;
      q.push_back(e);
      -> chk_ev;
      @(posedge clk);
      if (nx_we && nx_ws < 3'd5) m_bank[nx_ws] = nx_wd;
      if (nx_pv && nx_ps < 3'd5) begin m_pend = 1'b1; m_psel = nx_ps; end
      else if (nx_done) m_pend = 1'b0;
      nx_we = 0; nx_pv = 0; nx_done = 0;
   endtask

   task automatic do_wr(input logic [2:0] id, input logic [7:0] v);
      nx_we = 1; nx_ws = id; nx_wd = v;
      step(2'd0, 16'h0000, 1'b0, id, "R6 write");
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      nx_we = 0; nx_ws = 0; nx_wd = 0; nx_pv = 0; nx_ps = 0; nx_done = 0;
      rst_n = 0; rst_prog_bank = 8'h5A;
      acc_space = 0; acc_offset = 0; stk_sel = 0; wr_en = 0; wr_sel = 0;
      wr_data = 0; rd_sel = 0; pfx_valid = 0; pfx_sel = 0; insn_done = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      m_bank[0] = 8'h5A;
      for (int i = 1; i < 5; i++) m_bank[i] = 8'h00;
      m_pend = 0; m_psel = 3'd1;

      // R5 / R7: reset values through the read port and fetch address
      for (int i = 0; i < 5; i++) step(2'd0, 16'h1234, 1'b0, 3'(i), "R5 reset value");
      step(2'd1, 16'h00AB, 1'b0, 3'd6, "R7 bad id reads zero");

      // R6: same-cycle access sees the old bank, next cycle the new one
      nx_we = 1; nx_ws = 3'd1; nx_wd = 8'h11;
      step(2'd1, 16'h0010, 1'b0, 3'd1, "R6 old value in write cycle");
      step(2'd1, 16'h0010, 1'b0, 3'd1, "R6 new value next cycle");
      do_wr(3'd2, 8'h22);
      do_wr(3'd3, 8'h33);
      do_wr(3'd4, 8'h44);
      do_wr(3'd0, 8'h66);

      // R3 stack selection by flag
      step(2'd2, 16'h0100, 1'b0, 3'd2, "R3 user stack");
      step(2'd2, 16'h0102, 1'b1, 3'd3, "R3 system stack");
      // R4 default classes, R1 offset edge
      step(2'd3, 16'h4000, 1'b0, 3'd4, "R4 additional bank");
      step(2'd1, 16'h8000, 1'b1, 3'd1, "R4 data bank");
      step(2'd3, 16'hFFFF, 1'b0, 3'd4, "R1 offset 0xFFFF keeps bank");
      step(2'd0, 16'hFFFF, 1'b0, 3'd0, "R1 code offset top");

      // R8: writes to ids 5..7 change nothing
      nx_we = 1; nx_ws = 3'd6; nx_wd = 8'hEE;
      step(2'd1, 16'h0001, 1'b0, 3'd6, "R8 bad write cycle");
      nx_we = 1; nx_ws = 3'd7; nx_wd = 8'hDD;
      step(2'd3, 16'h0002, 1'b0, 3'd7, "R8 bad write cycle 2");
      for (int i = 0; i < 8; i++) step(2'd1, 16'h0003, 1'b0, 3'(i), "R8 registers unchanged");

      // R9: prefix redirects data/additional until completion
      nx_pv = 1; nx_ps = 3'd4;
      step(2'd0, 16'h0200, 1'b0, 3'd0, "R9 prefix cycle");
      step(2'd1, 16'h0204, 1'b0, 3'd4, "R9 data redirected");
      step(2'd0, 16'h0206, 1'b0, 3'd0, "R2 fetch ignores prefix");
      step(2'd2, 16'h0208, 1'b1, 3'd3, "R3 stack ignores prefix");
      nx_done = 1;
      step(2'd3, 16'h020A, 1'b0, 3'd4, "R9 last access before done");
      step(2'd1, 16'h020C, 1'b0, 3'd1, "R9 cleared after done");

      // R10: last prefix wins; prefix with done stays pending
      nx_pv = 1; nx_ps = 3'd2;
      step(2'd0, 16'h0300, 1'b0, 3'd0, "R10 first prefix");
      nx_pv = 1; nx_ps = 3'd3;
      step(2'd1, 16'h0302, 1'b0, 3'd2, "R10 first prefix in effect");
      step(2'd1, 16'h0304, 1'b0, 3'd3, "R10 last prefix wins");
      nx_pv = 1; nx_ps = 3'd0; nx_done = 1;
      step(2'd3, 16'h0306, 1'b0, 3'd3, "R10 prefix with done");
      step(2'd3, 16'h0308, 1'b0, 3'd0, "R10 new prefix kept");

      // R11: invalid prefix leaves pending state alone
      nx_pv = 1; nx_ps = 3'd7;
      step(2'd1, 16'h0400, 1'b0, 3'd0, "R11 invalid prefix cycle");
      step(2'd1, 16'h0402, 1'b0, 3'd0, "R11 pending unchanged");
      nx_pv = 1; nx_ps = 3'd5; nx_done = 1;
      step(2'd1, 16'h0404, 1'b0, 3'd1, "R11 invalid prefix with done");
      step(2'd1, 16'h0406, 1'b0, 3'd1, "R11 done cleared");
      nx_pv = 1; nx_ps = 3'd6;
      step(2'd3, 16'h0408, 1'b0, 3'd4, "R11 invalid prefix when idle");
      step(2'd3, 16'h040A, 1'b0, 3'd4, "R11 idle stays idle");

      // R5: second reset restores defaults
      @(negedge clk);
      rst_n = 0; rst_prog_bank = 8'hC3;
      @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      m_bank[0] = 8'hC3;
      for (int i = 1; i < 5; i++) m_bank[i] = 8'h00;
      m_pend = 0;
      step(2'd0, 16'h0500, 1'b0, 3'd0, "R5 reload from reset vector");
      step(2'd2, 16'h0502, 1'b1, 3'd3, "R5 stack bank cleared");

      @(negedge clk);
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule